// File: doc/BRIEF.md
# Serial Receive Buffer with Hardware Flow Control

This block is the receive half of an asynchronous serial port. It watches the serial line using an enable pulse that runs at sixteen times the bit rate. It checks each start bit, collects eight data bits LSB first, can check an even-parity bit, and then checks the stop bit. Each finished character is written to a buffer together with three error flags: parity, framing and break.

After reset the buffer holds a single character. When the `fifo_mode` input is set, it becomes a 16-entry queue. In queue mode the `rts` line can be driven by occupancy hysteresis, which pauses the remote sender before the queue fills. When hardware control is off, `rts` follows a level set by software.

A CPU uses two one-cycle strobes. One pops the head character. The other reads the status word and clears the sticky overrun flag. The `rxrdy` pin tells a DMA engine that data is waiting.

Top module: `serial_rx_buffer`

## Requirements
- R1: After reset the buffer is empty, `stat_out` is 0, `rxrdy` is 0, `rts` is 0 and the buffer capacity is one character.
- R2: A falling edge starts a character only if `rx_line` is still low on the 8th tick after the tick that saw it low. Otherwise the receiver goes back to idle and stores nothing.
- R3: After a start bit is accepted, data bits are sampled every 16 ticks, LSB first. When `par_en` is 1, a parity bit follows the 8th data bit. The stop bit is sampled 16 ticks after the last data or parity bit.
- R4: `stat_out` has these fields: bit0 data ready, bit1 overrun, bit2 parity error, bit3 framing error, bit4 break. Bits 2 to 4 belong to the head entry and read 0 when the buffer is empty. The parity error flag is set when `par_en` is 1 and the data bits plus the parity bit hold an odd number of ones. The framing error flag is set when the stop bit is 0. The break flag is set when the stop bit, all data bits and the parity bit (if used) are all 0.
- R5: With `fifo_mode` at 0, a character that finishes while one character is already held is discarded, and the overrun flag is set.
- R6: With `fifo_mode` at 1, the buffer holds 16 characters in arrival order. A 17th character is discarded, and the overrun flag is set.
- R7: The overrun flag stays set until a `rd_stat` strobe clears it.
- R8: A `rd_data` strobe removes the head entry, so the next entry's data and flags appear. A `rd_data` strobe on an empty buffer changes nothing.
- R9: Any change of `fifo_mode` empties the buffer. A character that finishes in that same cycle is lost.
- R10: When `fifo_mode` and `auto_flow` are both 1, `rts` goes low one cycle after the count reaches 14 or more. It goes high one cycle after the count falls below 8, and keeps its value in between. In every other case, `rts` copies `rts_req` one cycle later.
- R11: `rxrdy` is 1 exactly when the buffer is not empty.
- R12: After a character whose stop bit was 0, no new start is recognised until `rx_line` has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rx_line | input | 1 | Serial input, already synchronous to `clk` |
| par_en | input | 1 | Even-parity bit expected after data |
| fifo_mode | input | 1 | 0: single holding register, 1: 16-entry queue |
| auto_flow | input | 1 | Lets hysteresis drive `rts` in queue mode |
| rts_req | input | 1 | Software `rts` level when hysteresis is off |
| rd_data | input | 1 | Pop strobe for the head character |
| rd_stat | input | 1 | Status read strobe, clears overrun |
| data_out | output | 8 | Head character data |
| stat_out | output | 5 | Status word (see R4) |
| rxrdy | output | 1 | Data waiting, for a DMA engine |
| rts | output | 1 | Request-to-send toward the remote sender |

## Verification
The hardest situation to reach is the `rts` hysteresis band. It takes many back-to-back characters without any pops to climb to 14 entries, and the buffer must keep its contents while the stimulus pops it back below 8. The bench streams seventeen numbered characters in queue mode with hardware control on, which also forces the overrun. It then pops one entry at a time and checks `rts` at 8 and at 7 entries. A line held low for longer than a character is used to show the break and the wait for an idle line.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DW = 8;

  typedef struct packed {
    logic          brk;
    logic          frm;
    logic          par;
    logic [DW-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_WAITHI
  } rx_state_t;

  localparam int ST_RDY = 0;
  localparam int ST_OVR = 1;
  localparam int ST_PE  = 2;
  localparam int ST_FE  = 3;
  localparam int ST_BI  = 4;
  localparam int STW    = 5;
endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
  import srx_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      rx,
  input  logic      par_en,
  output logic      valid,
  output rx_entry_t entry
);
  localparam int CNTW = $clog2(OS);
  localparam int BITW = $clog2(DW);
  localparam logic [CNTW-1:0] MID  = CNTW'(OS/2 - 1);
  localparam logic [CNTW-1:0] LAST = CNTW'(OS - 1);
  localparam logic [BITW-1:0] TOPB = BITW'(DW - 1);

  rx_state_t       st;
  logic [CNTW-1:0] cnt;
  logic [BITW-1:0] bitn;
  logic [DW-1:0]   sh;
  logic            pb;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      sh    <= '0;
      pb    <= 1'b0;
      valid <= 1'b0;
      entry <= '0;
    end else begin
      valid <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: if (!rx) begin
            st  <= S_START;
            cnt <= '0;
          end
          S_START: if (cnt == MID) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= rx ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
          S_DATA: if (cnt == LAST) begin
            cnt      <= '0;
            sh[bitn] <= rx;
            if (bitn == TOPB) st <= par_en ? S_PAR : S_STOP;
            else bitn <= bitn + 1'b1;
          end else cnt <= cnt + 1'b1;
          S_PAR: if (cnt == LAST) begin
            cnt <= '0;
            pb  <= rx;
            st  <= S_STOP;
          end else cnt <= cnt + 1'b1;
          S_STOP: if (cnt == LAST) begin
            cnt        <= '0;
            valid      <= 1'b1;
            entry.data <= sh;
            entry.par  <= par_en & (^sh ^ pb);
            entry.frm  <= ~rx;
            entry.brk  <= ~rx & (sh == '0) & ~(par_en & pb);
            st         <= rx ? S_IDLE : S_WAITHI;
          end else cnt <= cnt + 1'b1;
          S_WAITHI: if (rx) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  assert_false_start_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_START && tick && cnt == MID && rx) |=> (st == S_IDLE && !valid));
  assert_wait_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAITHI && !rx) |=> (st == S_WAITHI));
endmodule

// File: rtl/srx_store.sv
module srx_store
  import srx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_valid,
  input  rx_entry_t      wr_entry,
  input  logic           fifo_mode,
  input  logic           rd_pop,
  input  logic           rd_stat,
  output logic [DW-1:0]  data_out,
  output logic [STW-1:0] stat_out,
  output logic [CW-1:0]  count
);
  localparam logic [CW-1:0] CAP_Q = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_1 = CW'(1);
  localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          mode_q, ovr_q;
  logic          flush, can_wr, lost, do_pop, rdy;
  logic [CW-1:0] cap;
  rx_entry_t     head;

  always_comb begin
    flush  = (fifo_mode != mode_q);
    cap    = mode_q ? CAP_Q : CAP_1;
    can_wr = wr_valid && !flush && (count < cap);
    lost   = wr_valid && !flush && (count >= cap);
    do_pop = rd_pop && !flush && (count != '0);
  end

  always_ff @(posedge clk) begin
    if (can_wr) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      mode_q <= fifo_mode;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        count  <= '0;
      end else begin
        if (can_wr) wr_ptr <= (wr_ptr == LASTP) ? '0 : wr_ptr + 1'b1;
        if (do_pop) rd_ptr <= (rd_ptr == LASTP) ? '0 : rd_ptr + 1'b1;
        count <= count + CW'(can_wr) - CW'(do_pop);
      end
      if (lost) ovr_q <= 1'b1;
      else if (rd_stat) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    head             = mem[rd_ptr];
    rdy              = (count != '0);
    data_out         = head.data;
    stat_out         = '0;
    stat_out[ST_RDY] = rdy;
    stat_out[ST_OVR] = ovr_q;
    stat_out[ST_PE]  = rdy & head.par;
    stat_out[ST_FE]  = rdy & head.frm;
    stat_out[ST_BI]  = rdy & head.brk;
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    count <= CAP_Q);
  assert_single_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> count <= CAP_1);
  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !rd_stat) |=> ovr_q);
  assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0));
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && count == '0 && !wr_valid) |=> (count == '0));
endmodule

// File: rtl/srx_flow.sv
module srx_flow #(
  parameter int CW      = 5,
  parameter int HI_MARK = 14,
  parameter int LO_MARK = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count,
  input  logic          fifo_mode,
  input  logic          auto_flow,
  input  logic          rts_req,
  output logic          rts
);
  localparam logic [CW-1:0] HI = CW'(HI_MARK);
  localparam logic [CW-1:0] LO = CW'(LO_MARK);

  logic hyst_q, hyst_nx, hw_ctl;

  always_comb begin
    hw_ctl  = fifo_mode && auto_flow;
    hyst_nx = hyst_q;
    if (count >= HI) hyst_nx = 1'b0;
    else if (count < LO) hyst_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hyst_q <= 1'b1;
      rts    <= 1'b0;
    end else begin
      hyst_q <= hyst_nx;
      rts    <= hw_ctl ? hyst_nx : rts_req;
    end
  end

  assert_rts_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (hw_ctl && count >= HI) |=> !rts);
  assert_rts_raise_R10: assert property (@(posedge clk) disable iff (rst)
    (hw_ctl && count < LO) |=> rts);
  assert_rts_manual_R10: assert property (@(posedge clk) disable iff (rst)
    !hw_ctl |=> (rts == $past(rts_req)));
endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer
  import srx_pkg::*;
#(
  parameter int OS      = 16,
  parameter int DEPTH   = 16,
  parameter int HI_MARK = 14,
  parameter int LO_MARK = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick16,
  input  logic           rx_line,
  input  logic           par_en,
  input  logic           fifo_mode,
  input  logic           auto_flow,
  input  logic           rts_req,
  input  logic           rd_data,
  input  logic           rd_stat,
  output logic [DW-1:0]  data_out,
  output logic [STW-1:0] stat_out,
  output logic           rxrdy,
  output logic           rts
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          ch_valid;
  rx_entry_t     ch_entry;
  logic [CW-1:0] level;

  srx_sampler #(.OS(OS)) u_sampler (
    .clk(clk), .rst(rst), .tick(tick16), .rx(rx_line), .par_en(par_en),
    .valid(ch_valid), .entry(ch_entry)
  );

  srx_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
    .clk(clk), .rst(rst), .wr_valid(ch_valid), .wr_entry(ch_entry),
    .fifo_mode(fifo_mode), .rd_pop(rd_data), .rd_stat(rd_stat),
    .data_out(data_out), .stat_out(stat_out), .count(level)
  );

  srx_flow #(.CW(CW), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_flow (
    .clk(clk), .rst(rst), .count(level), .fifo_mode(fifo_mode),
    .auto_flow(auto_flow), .rts_req(rts_req), .rts(rts)
  );

  assign rxrdy = (level != '0);

  assert_rxrdy_R11: assert property (@(posedge clk) disable iff (rst)
    rxrdy == stat_out[ST_RDY]);
endmodule

// File: tb/serial_rx_buffer_tb.sv
module serial_rx_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICKDIV    = 4;
  localparam int BITCYC     = 16 * TICKDIV;

  logic clk = 0, rst = 1, tick16 = 0, rx_line = 1, par_en = 0;
  logic fifo_mode = 0, auto_flow = 0, rts_req = 0, rd_data = 0, rd_stat = 0;
  logic [7:0] data_out;
  logic [4:0] stat_out;
  logic rxrdy, rts;

  int n_chk = 0, n_bad = 0, div = 0;
  bit done = 0;

  serial_rx_buffer u_dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_line(rx_line), .par_en(par_en),
    .fifo_mode(fifo_mode), .auto_flow(auto_flow), .rts_req(rts_req),
    .rd_data(rd_data), .rd_stat(rd_stat), .data_out(data_out),
    .stat_out(stat_out), .rxrdy(rxrdy), .rts(rts)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick16 <= (div == TICKDIV - 1);
    div    <= (div == TICKDIV - 1) ? 0 : div + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [10:0] q[$];
  logic m_ovr, m_modeq, m_hyst, m_rts, pend, m_pb;
  logic [10:0] pend_e;
  logic [7:0] m_sh;
  int m_st, m_cnt, m_bit;

  always @(posedge clk) begin : model
    int oc, cap;
    logic lost;
    if (rst) begin
      q.delete(); m_ovr = 0; m_modeq = 0; m_hyst = 1; m_rts = 0;
      m_st = 0; m_cnt = 0; m_bit = 0; m_sh = 0; m_pb = 0; pend = 0; pend_e = 0;
    end else begin
      oc = q.size();
      if (oc >= 14) m_hyst = 0; else if (oc < 8) m_hyst = 1;
      m_rts = (fifo_mode && auto_flow) ? m_hyst : rts_req;
      lost = 0;
      if (fifo_mode != m_modeq) q.delete();
      else begin
        cap = m_modeq ? 16 : 1;
        lost = pend && (oc >= cap);
        if (rd_data && oc > 0) void'(q.pop_front());
        if (pend && oc < cap) q.push_back(pend_e);
      end
      if (lost) m_ovr = 1; else if (rd_stat) m_ovr = 0;
      m_modeq = fifo_mode;
      pend = 0;
      if (tick16) begin
        case (m_st)
          0: if (!rx_line) begin m_st = 1; m_cnt = 0; end
          1: if (m_cnt == 7) begin m_cnt = 0; m_bit = 0; m_st = rx_line ? 0 : 2; end
             else m_cnt++;
          2: if (m_cnt == 15) begin
               m_cnt = 0; m_sh[m_bit] = rx_line;
               if (m_bit == 7) m_st = par_en ? 3 : 4; else m_bit++;
             end else m_cnt++;
          3: if (m_cnt == 15) begin m_cnt = 0; m_pb = rx_line; m_st = 4; end
             else m_cnt++;
          4: if (m_cnt == 15) begin
               m_cnt = 0; pend = 1;
               pend_e = {~rx_line & (m_sh == 0) & ~(par_en & m_pb), ~rx_line,
                         par_en & (^m_sh ^ m_pb), m_sh};
               m_st = rx_line ? 0 : 5;
             end else m_cnt++;
          default: if (rx_line) m_st = 0;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      logic [4:0] es;
      logic rdy;
      rdy = (q.size() != 0);
      es = {rdy & (rdy ? q[0][10] : 1'b0), rdy & (rdy ? q[0][9] : 1'b0),
            rdy & (rdy ? q[0][8] : 1'b0), m_ovr, rdy};
      chk("R11 rxrdy", rxrdy, rdy);
      chk("R10 rts", rts, m_rts);
      chk("R4 stat_out", stat_out, es);
      if (rdy) chk("R3 data_out", data_out, q[0][7:0]);
    end
  end

  task automatic drive_bit(input logic b);
    rx_line = b;
    repeat (BITCYC) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic use_par, input logic pbit,
                      input logic stopb);
    drive_bit(0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (use_par) drive_bit(pbit);
    drive_bit(stopb);
    rx_line = 1;
    repeat (2 * BITCYC) @(negedge clk);
  endtask

  task automatic pulse_pop();
    rd_data = 1; @(negedge clk); rd_data = 0; @(negedge clk);
  endtask

  task automatic pulse_stat();
    rd_stat = 1; @(negedge clk); rd_stat = 0; @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 stat", stat_out, 0);
    chk("R1 rxrdy", rxrdy, 0);
    chk("R1 rts", rts, 0);

    // R3 single-character mode reception
    send(8'hA5, 0, 0, 1);
    chk("R3 data", data_out, 8'hA5);
    chk("R11 rxrdy set", rxrdy, 1);
    // R5 second character overruns the single holding register
    send(8'h3C, 0, 0, 1);
    chk("R5 held data kept", data_out, 8'hA5);
    chk("R5 overrun", stat_out, 5'b00011);
    pulse_stat();
    chk("R7 overrun cleared", stat_out, 5'b00001);
    pulse_pop();
    chk("R8 popped", stat_out, 0);
    pulse_pop();
    chk("R8 pop on empty", rxrdy, 0);

    // R2 short glitch rejected
    rx_line = 0; repeat (3 * TICKDIV) @(negedge clk); rx_line = 1;
    repeat (2 * BITCYC) @(negedge clk);
    chk("R2 glitch ignored", rxrdy, 0);

    // R4 parity error: 0x07 has three ones, parity bit 0 gives odd total
    par_en = 1;
    send(8'h07, 1, 0, 1);
    chk("R4 parity error", stat_out, 5'b00101);
    pulse_pop();
    send(8'h07, 1, 1, 1);
    chk("R4 parity good", stat_out, 5'b00001);
    pulse_pop();
    par_en = 0;
    // R4 framing error
    send(8'h55, 0, 0, 0);
    chk("R4 framing", stat_out, 5'b01001);
    pulse_pop();
    // R12 break with long low line yields a single entry
    rx_line = 0; repeat (14 * BITCYC) @(negedge clk);
    chk("R12 one entry", stat_out, 5'b11001);
    rx_line = 1; repeat (2 * BITCYC) @(negedge clk);
    chk("R12 no extra", stat_out, 5'b11001);
    pulse_pop();

    // R9 mode change flushes
    send(8'h11, 0, 0, 1);
    fifo_mode = 1; auto_flow = 1;
    repeat (3) @(negedge clk);
    chk("R9 flushed", rxrdy, 0);

    // R6, R10 queue fill with hardware flow control
    for (int i = 0; i < 17; i++) begin
      send(8'h20 + 8'(i), 0, 0, 1);
      if (i == 12) chk("R10 rts high at 13", rts, 1);
      if (i == 13) chk("R10 rts low at 14", rts, 0);
    end
    chk("R6 overrun on 17th", stat_out[1], 1);
    chk("R6 head first", data_out, 8'h20);
    for (int i = 0; i < 8; i++) begin
      chk("R6 order", data_out, 8'h20 + 8'(i));
      pulse_pop();
    end
    @(negedge clk);
    chk("R10 rts held at 8", rts, 0);
    pulse_pop();
    @(negedge clk);
    chk("R10 rts high at 7", rts, 1);
    chk("R8 next head", data_out, 8'h29);

    // R10 manual control when hardware control off
    auto_flow = 0; rts_req = 0;
    repeat (2) @(negedge clk);
    chk("R10 manual low", rts, 0);
    rts_req = 1;
    repeat (2) @(negedge clk);
    chk("R10 manual high", rts, 1);

    // R9 leaving queue mode flushes
    fifo_mode = 0;
    repeat (2) @(negedge clk);
    chk("R9 flush on exit", rxrdy, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule